// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell Bank

This block joins internal logic outputs to a row of bidirectional pads. Each pad has its own cell with a small configuration word. The word sets the direction mode: input only, permanently driven output, or bidirectional with three-state control. It also sets the drive style (push-pull or open-drain), the source of the output enable, and a slew-rate flag. Core logic writes a cell's word on a clock edge. From then on, the pad path is combinational from the internal data, the per-cell product-term enable and the two shared global enables.

The level on every pad is always returned to the core as routing input, including while the cell drives it. A drive indicator tells the core whether each cell is actively driving its pad. The slew flag is only reported to the core; it does not change how the pad is driven. After reset every cell is unconfigured: input only, push-pull, slow slew, and the pad is released.

Top module: `iocell_bank`

## Requirements
- R1: After a synchronous active-low reset every cell's configuration is all zeros: input only, push-pull, enable source product term, slow slew. No pad is driven, and `slew_fast_o` reads 0.
- R2: A configuration word on `cfg_wdata` is stored into every cell whose `cfg_we` bit is 1, at the rising clock edge. Cells whose bit is 0 keep their word. Word layout: bit 5 slew fast, bit 4 open-drain, bits 3:2 enable source, bits 1:0 mode.
- R3: Mode 00 (input only) never drives the pad, whatever the data and enable inputs are.
- R4: Mode 01 (output) treats the enable as always active. The enable-source field, the product-term enable and the global enables have no effect.
- R5: In mode 10 (bidirectional) the enable is taken from the enable-source field: 00 the cell's `pt_oe_i`, 01 `goe_i[0]`, 10 `goe_i[1]`, 11 always active. The global enables are active high.
- R6: When the effective enable is inactive, the pad is released to high impedance, and a level driven from outside appears on the pad.
- R7: In push-pull style (bit 4 = 0), an enabled cell drives `dout_i` onto the pad at both levels.
- R8: In open-drain style (bit 4 = 1), an enabled cell drives low only when `dout_i` is 0. When `dout_i` is 1 it releases the pad.
- R9: `pad_in_o` always equals the pad level, both while the cell drives and while it is released.
- R10: Bit 5 appears on `slew_fast_o` for that cell and has no effect on driving.
- R11: Mode 11 behaves like input only and never drives the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | N_CELLS | Per-cell configuration write strobe |
| cfg_wdata | input | 6 | Configuration word written to the strobed cells |
| dout_i | input | N_CELLS | Internal data to drive on each pad |
| pt_oe_i | input | N_CELLS | Per-cell product-term output enable |
| goe_i | input | 2 | Global output enables, active high |
| pad_io | inout | N_CELLS | Bidirectional pads |
| pad_in_o | output | N_CELLS | Pad level returned to the routing |
| pad_drv_o | output | N_CELLS | Cell is actively driving its pad |
| slew_fast_o | output | N_CELLS | Stored slew flag per cell |

## Verification
On every cycle, the assertions check four things. Input-only and reserved modes never drive. A push-pull output-mode cell always drives. An open-drain cell that drives holds its pad low. A bidirectional cell that follows a global enable is silent while that enable is low. The configuration store is checked to hold its word without a strobe and to load it with one. Only the bench scenarios can show the remaining behaviour, because it needs an external driver on the pads and a model of what should appear there. That covers the exact levels seen on the pads and on the read-back path, release to an outside level, each enable-source choice, and the independence of the cells and of the slew flag.

// File: rtl/iocell_pkg.sv
// Shared types for the pad cell bank.
// Assumes a 6-bit configuration word whose field order is fixed by the struct below.
package iocell_pkg;

    typedef enum logic [1:0] {
        MODE_IN    = 2'b00,
        MODE_OUT   = 2'b01,
        MODE_BIDIR = 2'b10,
        MODE_RSVD  = 2'b11
    } io_mode_e;

    typedef enum logic [1:0] {
        OE_PTERM  = 2'b00,
        OE_GLB0   = 2'b01,
        OE_GLB1   = 2'b10,
        OE_ALWAYS = 2'b11
    } oe_src_e;

    typedef struct packed {
        logic     slew_fast;
        logic     open_drain;
        oe_src_e  oe_src;
        io_mode_e mode;
    } io_cfg_t;

    localparam int CFG_W = $bits(io_cfg_t);
    localparam int N_GOE = 2;

endpackage

// File: rtl/iocell_cfg_store.sv
// Per-cell configuration register.
// Loads the word on a strobe and clears to the unconfigured state on reset.
// Assumes a synchronous active-low reset.
module iocell_cfg_store
    import iocell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output io_cfg_t          cfg_o
);

    io_cfg_t cfg_q;

    // Hold the cell word; reset gives input only, push-pull, slow slew.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (we)
            cfg_q <= io_cfg_t'(wdata);
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q)); // R2
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(wdata))); // R2

endmodule

// File: rtl/iocell_oe_mux.sv
// Effective output-enable selection for one cell.
// Output mode forces the enable on; bidirectional mode picks a source;
// input-only and reserved modes force it off. Global enables are active high.
module iocell_oe_mux
    import iocell_pkg::*;
(
    input  io_mode_e         mode,
    input  oe_src_e          oe_src,
    input  logic             pt_oe,
    input  logic [N_GOE-1:0] goe,
    output logic             en_o
);

    logic src_en;

    // Pick the enable named by the source field.
    always_comb begin
        unique case (oe_src)
            OE_PTERM: src_en = pt_oe;
            OE_GLB0:  src_en = goe[0];
            OE_GLB1:  src_en = goe[1];
            default:  src_en = 1'b1;
        endcase
    end

    // Apply the direction mode on top of the selected source.
    always_comb begin
        unique case (mode)
            MODE_OUT:   en_o = 1'b1;
            MODE_BIDIR: en_o = src_en;
            default:    en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/iocell_pad_drv.sv
// Pad driver decision for one cell.
// Push-pull drives either level; open-drain drives only a low and
// releases for a high. Assumes a pull-up outside the block for open-drain.
module iocell_pad_drv (
    input  logic en,
    input  logic open_drain,
    input  logic dout,
    output logic drv_o,
    output logic val_o
);

    // Decide whether the pad is driven and with which level.
    always_comb begin
        drv_o = en && (!open_drain || !dout);
        val_o = open_drain ? 1'b0 : dout;
    end

endmodule

// File: rtl/iocell_bank.sv
// Bank of configurable bidirectional pad cells.
// Each cell has its own configuration store, enable selection and driver.
// The pad level is always read back to the core. Assumes a synchronous
// active-low reset and that outside drivers avoid pads a cell is driving.
module iocell_bank
    import iocell_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [N_CELLS-1:0] dout_i,
    input  logic [N_CELLS-1:0] pt_oe_i,
    input  logic [N_GOE-1:0]   goe_i,
    inout  wire  [N_CELLS-1:0] pad_io,
    output logic [N_CELLS-1:0] pad_in_o,
    output logic [N_CELLS-1:0] pad_drv_o,
    output logic [N_CELLS-1:0] slew_fast_o
);

    io_cfg_t            cell_cfg [N_CELLS];
    logic [N_CELLS-1:0] cell_en;
    logic [N_CELLS-1:0] cell_drv;
    logic [N_CELLS-1:0] cell_val;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        iocell_cfg_store u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cfg_we[i]),
            .wdata (cfg_wdata),
            .cfg_o (cell_cfg[i])
        );

        iocell_oe_mux u_oe (
            .mode   (cell_cfg[i].mode),
            .oe_src (cell_cfg[i].oe_src),
            .pt_oe  (pt_oe_i[i]),
            .goe    (goe_i),
            .en_o   (cell_en[i])
        );

        iocell_pad_drv u_drv (
            .en         (cell_en[i]),
            .open_drain (cell_cfg[i].open_drain),
            .dout       (dout_i[i]),
            .drv_o      (cell_drv[i]),
            .val_o      (cell_val[i])
        );

        // Three-state pad driver.
        assign pad_io[i] = cell_drv[i] ? cell_val[i] : 1'bz;

        AST_IN_NODRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_cfg[i].mode == MODE_IN || cell_cfg[i].mode == MODE_RSVD)
            |-> !pad_drv_o[i]); // R3 R11
        AST_OUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_cfg[i].mode == MODE_OUT && !cell_cfg[i].open_drain)
            |-> pad_drv_o[i]); // R4
        AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_cfg[i].open_drain && pad_drv_o[i]) |-> (pad_io[i] == 1'b0)); // R8
        AST_GOE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_cfg[i].mode == MODE_BIDIR &&
             ((cell_cfg[i].oe_src == OE_GLB0 && !goe_i[0]) ||
              (cell_cfg[i].oe_src == OE_GLB1 && !goe_i[1])))
            |-> !pad_drv_o[i]); // R5 R6
    end

    // Core-side view of the pads and of the stored flags.
    always_comb begin
        pad_in_o  = pad_io;
        pad_drv_o = cell_drv;
        for (int k = 0; k < N_CELLS; k++)
            slew_fast_o[k] = cell_cfg[k].slew_fast;
    end

endmodule

// File: tb/sim_iocell_bank.sv
module sim_iocell_bank;

    localparam int N = 4;

    typedef struct {
        logic [N-1:0] drv;
        logic [N-1:0] pin;
        logic [N-1:0] slew;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cfg_we = '0;
    logic [5:0]   cfg_wdata = '0;
    logic [N-1:0] dout = '0;
    logic [N-1:0] pt_oe = '0;
    logic [1:0]   goe = '0;
    logic [N-1:0] ext_en = '0;
    logic [N-1:0] ext_val = '0;
    wire  [N-1:0] pad;
    logic [N-1:0] pad_in, pad_drv, slew_fast;

    logic [5:0] mdl_cfg [N];
    exp_t       sb_q [$];
    event       ev_item;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_ext
        assign pad[g] = ext_en[g] ? ext_val[g] : 1'bz;
    end

    iocell_bank #(.N_CELLS(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .dout_i      (dout),
        .pt_oe_i     (pt_oe),
        .goe_i       (goe),
        .pad_io      (pad),
        .pad_in_o    (pad_in),
        .pad_drv_o   (pad_drv),
        .slew_fast_o (slew_fast)
    );

    // Model of one cell's drive decision, written from the requirements.
    function automatic logic model_drv(logic [5:0] c, logic d, logic pt, logic [1:0] ge);
        logic en;
        case (c[1:0])
            2'b01:   en = 1'b1;
            2'b10:   case (c[3:2])
                         2'b00: en = pt;
                         2'b01: en = ge[0];
                         2'b10: en = ge[1];
                         default: en = 1'b1;
                     endcase
            default: en = 1'b0;
        endcase
        return en && (!c[4] || !d);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) mdl_cfg[i] = '0;
    endtask

    task automatic write_cfg(logic [N-1:0] mask, logic [5:0] data);
        @(negedge clk);
        cfg_we = mask;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = '0;
        for (int i = 0; i < N; i++) if (mask[i]) mdl_cfg[i] = data;
    endtask

    // Driver: apply stimulus, push the expected result, hand over to the monitor.
    task automatic apply(logic [N-1:0] d, logic [N-1:0] pt, logic [1:0] ge,
                         logic [N-1:0] outside, string req);
        exp_t e;
        @(negedge clk);
        dout = d;
        pt_oe = pt;
        goe = ge;
        for (int i = 0; i < N; i++) begin
            e.drv[i]  = model_drv(mdl_cfg[i], d[i], pt[i], ge);
            e.pin[i]  = e.drv[i] ? (mdl_cfg[i][4] ? 1'b0 : d[i]) : outside[i];
            e.slew[i] = mdl_cfg[i][5];
        end
        ext_en = ~e.drv;
        ext_val = outside;
        e.req = req;
        sb_q.push_back(e);
        ->ev_item;
        @(posedge clk);
    endtask

    // Monitor: pop expected items and compare away from the clock edge.
    initial begin
        forever begin
            @(ev_item);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (pad_drv !== e.drv) begin
                    n_fail++;
                    $display("FAIL %s drive: actual %b expected %b", e.req, pad_drv, e.drv);
                end
                n_checks++;
                if (pad_in !== e.pin) begin
                    n_fail++;
                    $display("FAIL %s R9 pad level: actual %b expected %b", e.req, pad_in, e.pin);
                end
                n_checks++;
                if (slew_fast !== e.slew) begin
                    n_fail++;
                    $display("FAIL %s slew flag: actual %b expected %b", e.req, slew_fast, e.slew);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        apply(4'b0000, 4'b0000, 2'b00, 4'b1010, "R1");
        apply(4'b1111, 4'b1111, 2'b11, 4'b0101, "R3");

        write_cfg(4'b0001, 6'b000001);            // cell0 output, push-pull
        apply(4'b0101, 4'b0000, 2'b00, 4'b1010, "R2 R4 R7");
        apply(4'b0100, 4'b1111, 2'b11, 4'b1011, "R4 R7");

        write_cfg(4'b0010, 6'b000010);            // cell1 bidir, product term
        write_cfg(4'b0100, 6'b000110);            // cell2 bidir, global 0
        write_cfg(4'b1000, 6'b001010);            // cell3 bidir, global 1
        apply(4'b1111, 4'b0000, 2'b00, 4'b0000, "R5 R6");
        apply(4'b1110, 4'b0010, 2'b00, 4'b0001, "R5 pterm");
        apply(4'b1110, 4'b0000, 2'b01, 4'b1011, "R5 goe0");
        apply(4'b0000, 4'b1111, 2'b10, 4'b1111, "R5 goe1");
        apply(4'b1010, 4'b0000, 2'b11, 4'b0101, "R5 R7 both");

        write_cfg(4'b0001, 6'b001110);            // cell0 bidir, always
        apply(4'b0001, 4'b0000, 2'b00, 4'b1110, "R5 always");

        write_cfg(4'b0010, 6'b010010);            // cell1 open-drain
        apply(4'b0000, 4'b0010, 2'b00, 4'b1111, "R8 low");
        apply(4'b0010, 4'b0010, 2'b00, 4'b0010, "R8 release");

        write_cfg(4'b0100, 6'b100110);            // cell2 fast slew
        apply(4'b0100, 4'b0000, 2'b01, 4'b0000, "R10 on");
        apply(4'b0000, 4'b0000, 2'b00, 4'b0100, "R10 off");

        write_cfg(4'b1000, 6'b001111);            // cell3 reserved mode
        apply(4'b1000, 4'b1111, 2'b11, 4'b0000, "R11");

        do_reset();
        apply(4'b1111, 4'b1111, 2'b11, 4'b0110, "R1 again");

        #20;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule